// File: doc/BRIEF.md
# Store Regeneration and Access Sequencer

This block schedules every access to a store that loses its contents unless each location is rewritten from time to time. A strobe from the machine's timing track marks the edges of fixed periods. The block divides that strobe by two, so that refresh periods and working ("act") periods alternate. It divides the act periods by two again, so that they alternate between fetching an instruction and accessing that instruction's operand. One instruction therefore takes one refresh/act pair for its fetch and the next pair for its operand access.

For every period, the block picks which address reaches the store. In a refresh period the address comes from an internal sweep counter that runs through every location whatever the program is doing. In a fetch period it comes from the instruction counter. In an operand period it comes from the operand-address field. The block also drives the store's read enable and write enable, and a loop-break signal. Loop-break replaces the read-back refresh data with new data, and only a store-type instruction raises it, in its operand period. The counters that supply the instruction and operand addresses, and the store itself, lie outside the block.

Top module: `store_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) wins over `tick`. After that edge the block is in a refresh period (`phase` = 0), the sweep counter is 0 so `store_addr` = 0, and the next act period will be a fetch.
- R2: Each clock edge with `tick` high and `rst` low switches between refresh and act periods. With `tick` low, the period, the period kind and the sweep counter all hold.
- R3: Act periods alternate strictly between fetch and operand access. The first act period after reset is a fetch.
- R4: In a refresh period `store_addr` equals the sweep counter. The counter rises by one at each edge that ends a refresh period (`tick` high while `phase` = 0), and it wraps from 2^ADDR_W-1 to 0. With the default ADDR_W = 10 it covers 1024 locations.
- R5: In a fetch period `store_addr` equals `instr_addr`. In an operand period it equals `oper_addr`. Both paths are combinational, with no cycle of delay.
- R6: `phase` encodes the current period as 2'd0 for refresh, 2'd1 for fetch and 2'd2 for operand access. The value 2'd3 never appears.
- R7: `rd_en` is high in refresh periods, in fetch periods and in operand periods of non-store instructions. It is low in an operand period when `op_type` equals STORE_OP (default 5'd5).
- R8: `wr_en` is high in refresh periods, where the read value is written back, and in store operand periods. It is low in fetch periods and in non-store operand periods.
- R9: `loop_brk` is high only in an operand period with `op_type` = STORE_OP. In every other case it is low.
- R10: The sweep counter moves only at the ends of refresh periods. The values on `instr_addr`, `oper_addr` and `op_type` never change the sequence of refresh addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timing-track strobe; one cycle high marks a period boundary |
| instr_addr | input | ADDR_W | Address from the instruction counter |
| oper_addr | input | ADDR_W | Operand-address field of the current instruction |
| op_type | input | OP_W | Instruction type code |
| store_addr | output | ADDR_W | Address driven to the store |
| phase | output | 2 | Current period: 0 refresh, 1 fetch, 2 operand |
| rd_en | output | 1 | Store read enable |
| wr_en | output | 1 | Store write enable |
| loop_brk | output | 1 | Breaks the refresh feedback so new data is written |

## Verification
The bench builds the block with its defaults: ADDR_W = 10, OP_W = 5, STORE_OP = 5 and an upward sweep. A stretch with `tick` high on every cycle drives more than 1024 refresh periods, which takes the sweep counter through its wrap from 1023 to 0. Sparse and random tick spacing exercises the hold behaviour. Random operand codes, with the store code weighted up, reach both branches of the enable decode. A reset held with `tick` high partway through the run shows that reset wins and that the fetch/operand order starts again.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      PH_REGEN = 2'd0,
      PH_FETCH = 2'd1,
      PH_EXEC  = 2'd2
   } phase_e;

endpackage

// File: rtl/seq_period_div.sv
module seq_period_div
   import seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   tick,
   output phase_e phase,
   output logic   regen_end
);

   logic in_act;
   logic next_exec;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_act    <= 1'b0;
         next_exec <= 1'b0;
      end else if (tick) begin
         in_act <= ~in_act;
         if (in_act) begin
            next_exec <= ~next_exec;
         end
      end
   end

   always_comb begin
      if (!in_act) begin
         phase = PH_REGEN;
      end else if (next_exec) begin
         phase = PH_EXEC;
      end else begin
         phase = PH_FETCH;
      end
   end

   assign regen_end = tick & ~in_act;

endmodule

// File: rtl/seq_refresh_ctr.sv
module seq_refresh_ctr #(
   parameter int ADDR_W = 10,
   parameter bit SWEEP_DOWN = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ADDR_W-1:0] count
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (SWEEP_DOWN) begin : g_down
         always_ff @(posedge clk) begin
            if (rst) begin
               count <= '0;
            end else if (step) begin
               count <= count - ONE;
            end
         end
      end else begin : g_up
         always_ff @(posedge clk) begin
            if (rst) begin
               count <= '0;
            end else if (step) begin
               count <= count + ONE;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/seq_addr_sel.sv
module seq_addr_sel
   import seq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] sweep_addr,
   input  logic [ADDR_W-1:0] instr_addr,
   input  logic [ADDR_W-1:0] oper_addr,
   output logic [ADDR_W-1:0] store_addr
);

   always_comb begin
      unique case (phase)
         PH_FETCH: store_addr = instr_addr;
         PH_EXEC:  store_addr = oper_addr;
         default:  store_addr = sweep_addr;
      endcase
   end

endmodule

// File: rtl/seq_enable_dec.sv
module seq_enable_dec
   import seq_pkg::*;
#(
   parameter int OP_W     = 5,
   parameter int STORE_OP = 5
) (
   input  phase_e          phase,
   input  logic [OP_W-1:0] op_type,
   output logic            rd_en,
   output logic            wr_en,
   output logic            loop_brk
);

   localparam logic [OP_W-1:0] STORE_CODE = OP_W'(STORE_OP);

   logic is_store_exec;

   assign is_store_exec = (phase == PH_EXEC) && (op_type == STORE_CODE);

   always_comb begin
      rd_en    = 1'b1;
      wr_en    = 1'b0;
      loop_brk = 1'b0;
      if (phase == PH_REGEN) begin
         wr_en = 1'b1;
      end else if (is_store_exec) begin
         rd_en    = 1'b0;
         wr_en    = 1'b1;
         loop_brk = 1'b1;
      end
   end

endmodule

// File: rtl/store_sequencer.sv
module store_sequencer
   import seq_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int OP_W       = 5,
   parameter int STORE_OP   = 5,
   parameter bit SWEEP_DOWN = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [ADDR_W-1:0] instr_addr,
   input  logic [ADDR_W-1:0] oper_addr,
   input  logic [OP_W-1:0]   op_type,
   output logic [ADDR_W-1:0] store_addr,
   output logic [1:0]        phase,
   output logic              rd_en,
   output logic              wr_en,
   output logic              loop_brk
);

   generate
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr_w
         $error("store_sequencer: ADDR_W out of range");
      end
      if (OP_W < 1 || OP_W > 16) begin : g_bad_op_w
         $error("store_sequencer: OP_W out of range");
      end
      if (STORE_OP < 0 || STORE_OP >= (1 << OP_W)) begin : g_bad_store_op
         $error("store_sequencer: STORE_OP does not fit OP_W");
      end
   endgenerate

   phase_e            cur_phase;
   logic              regen_end;
   logic [ADDR_W-1:0] sweep_addr;

   seq_period_div u_div (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .phase     (cur_phase),
      .regen_end (regen_end)
   );

   seq_refresh_ctr #(
      .ADDR_W     (ADDR_W),
      .SWEEP_DOWN (SWEEP_DOWN)
   ) u_sweep (
      .clk   (clk),
      .rst   (rst),
      .step  (regen_end),
      .count (sweep_addr)
   );

   seq_addr_sel #(
      .ADDR_W (ADDR_W)
   ) u_sel (
      .phase      (cur_phase),
      .sweep_addr (sweep_addr),
      .instr_addr (instr_addr),
      .oper_addr  (oper_addr),
      .store_addr (store_addr)
   );

   seq_enable_dec #(
      .OP_W     (OP_W),
      .STORE_OP (STORE_OP)
   ) u_en (
      .phase    (cur_phase),
      .op_type  (op_type),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .loop_brk (loop_brk)
   );

   assign phase = cur_phase;

endmodule

// File: rtl/store_sequencer_chk.sv
module store_sequencer_chk #(
   parameter int ADDR_W     = 10,
   parameter int OP_W       = 5,
   parameter int STORE_OP   = 5,
   parameter bit SWEEP_DOWN = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic [ADDR_W-1:0] instr_addr,
   input logic [ADDR_W-1:0] oper_addr,
   input logic [OP_W-1:0]   op_type,
   input logic [ADDR_W-1:0] store_addr,
   input logic [1:0]        phase,
   input logic              rd_en,
   input logic              wr_en,
   input logic              loop_brk
);

   localparam logic [OP_W-1:0]   ST   = OP_W'(STORE_OP);
   localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] exp_sweep;
   logic              last_fetch;
   logic              prev_regen;

   always_ff @(posedge clk) begin
      if (rst) begin
         exp_sweep  <= '0;
         last_fetch <= 1'b0;
         prev_regen <= 1'b1;
      end else begin
         prev_regen <= (phase == 2'd0);
         if (phase == 2'd0 && tick) begin
            exp_sweep <= SWEEP_DOWN ? store_addr - ONE : store_addr + ONE;
         end
         if (phase == 2'd1) last_fetch <= 1'b1;
         if (phase == 2'd2) last_fetch <= 1'b0;
      end
   end

   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(phase));

   p_regen_to_act_r2: assert property (@(posedge clk) disable iff (rst)
      (tick && phase == 2'd0) |=> (phase != 2'd0));

   p_act_to_regen_r2: assert property (@(posedge clk) disable iff (rst)
      (tick && phase != 2'd0) |=> (phase == 2'd0));

   p_fetch_exec_alt_r3: assert property (@(posedge clk) disable iff (rst)
      (phase != 2'd0 && prev_regen) |-> (phase == (last_fetch ? 2'd2 : 2'd1)));

   p_sweep_step_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd0 && !prev_regen) |-> (store_addr == exp_sweep));

   p_fetch_addr_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd1) |-> (store_addr == instr_addr));

   p_exec_addr_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd2) |-> (store_addr == oper_addr));

   p_phase_legal_r6: assert property (@(posedge clk) disable iff (rst)
      phase != 2'd3);

   p_store_exec_rw_r7: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd2 && op_type == ST) |-> (!rd_en && wr_en));

   p_fetch_no_write_r8: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd1) |-> (rd_en && !wr_en));

   p_brk_only_store_r9: assert property (@(posedge clk) disable iff (rst)
      loop_brk |-> (phase == 2'd2 && op_type == ST));

endmodule

bind store_sequencer store_sequencer_chk #(
   .ADDR_W     (ADDR_W),
   .OP_W       (OP_W),
   .STORE_OP   (STORE_OP),
   .SWEEP_DOWN (SWEEP_DOWN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .tick       (tick),
   .instr_addr (instr_addr),
   .oper_addr  (oper_addr),
   .op_type    (op_type),
   .store_addr (store_addr),
   .phase      (phase),
   .rd_en      (rd_en),
   .wr_en      (wr_en),
   .loop_brk   (loop_brk)
);

// File: tb/tb_store_sequencer.sv
module tb_store_sequencer;

   localparam int AW = 10;
   localparam int OW = 5;
   localparam int SO = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b0;
   logic [AW-1:0] instr_addr = '0;
   logic [AW-1:0] oper_addr = '0;
   logic [OW-1:0] op_type = '0;
   logic [AW-1:0] store_addr;
   logic [1:0]    phase;
   logic          rd_en, wr_en, loop_brk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_act = 0;
   int m_nexe = 0;
   int m_ref = 0;

   always #10 clk = ~clk;

   store_sequencer dut (
      .clk(clk), .rst(rst), .tick(tick),
      .instr_addr(instr_addr), .oper_addr(oper_addr), .op_type(op_type),
      .store_addr(store_addr), .phase(phase),
      .rd_en(rd_en), .wr_en(wr_en), .loop_brk(loop_brk)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int ep;
      bit st;
      int ea;
      ep = (m_act == 0) ? 0 : (m_nexe != 0 ? 2 : 1);
      st = (ep == 2) && (int'(op_type) == SO);
      ea = (ep == 0) ? m_ref : (ep == 1 ? int'(instr_addr) : int'(oper_addr));
      chk("R6 R3 R2 phase", int'(phase), ep);
      if (ep == 0) chk("R4 R10 sweep addr", int'(store_addr), ea);
      else         chk("R5 access addr", int'(store_addr), ea);
      chk("R7 rd_en", int'(rd_en), st ? 0 : 1);
      chk("R8 wr_en", int'(wr_en), (ep == 0 || st) ? 1 : 0);
      chk("R9 loop_brk", int'(loop_brk), st ? 1 : 0);
   endtask

   task automatic step(input bit r, input bit t);
      @(negedge clk);
      rst  = r;
      tick = t;
      instr_addr = AW'($urandom);
      oper_addr  = AW'($urandom);
      op_type    = (($urandom % 3) == 0) ? OW'(SO) : OW'($urandom);
      #1;
      if (!rst) compare();
      @(posedge clk);
      #1;
      if (r) begin
         m_act = 0; m_nexe = 0; m_ref = 0;
      end else if (t) begin
         if (m_act == 0) m_ref = (m_ref + 1) % (1 << AW);
         else m_nexe = 1 - m_nexe;
         m_act = 1 - m_act;
      end
   endtask

   task automatic reset_check();
      @(negedge clk);
      rst = 1'b0; tick = 1'b0;
      #1;
      chk("R1 reset phase", int'(phase), 0);
      chk("R1 reset addr", int'(store_addr), 0);
      chk("R1 reset wr_en", int'(wr_en), 1);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
      reset_check();
      // first act after reset is a fetch (R3)
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      // holding without tick (R2)
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
      // dense ticks: sweep wraps 1023 -> 0 (R4)
      for (int i = 0; i < 2200; i++) step(1'b0, 1'b1);
      chk("R4 wrap reached", (m_ref < 100) ? 1 : 0, 1);
      // sparse ticks every third cycle
      for (int i = 0; i < 300; i++) step(1'b0, (i % 3) == 2);
      // random tick spacing
      for (int i = 0; i < 3000; i++) step(1'b0, ($urandom % 4) == 0);
      // reset mid-run with tick high: reset wins (R1)
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      reset_check();
      for (int i = 0; i < 400; i++) step(1'b0, ($urandom % 2) == 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule